// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside the execution core of a small 8-bit processor. It watches three external pins: an edge-triggered non-maskable request, a level request that can be masked, and a set-overflow pin. At each instruction boundary that the core signals, it decides whether an interrupt must be entered. When one is, it runs a fixed entry sequence. The sequence pushes the return address and the status byte onto the stack page and pulses a request to set the interrupt-disable flag. It then reads the two vector bytes, low byte first.

The core supplies the current interrupt-disable flag and the return address to save. It also supplies the status byte to push and a strobe marking each instruction boundary. When an instruction has just re-enabled interrupts, the core raises a separate flag. That flag delays a masked request by one instruction, so the instruction that follows the re-enable always runs. After reset the block owns the stack pointer and fetches the reset vector before it hands control back to the core.

Top module: `irq_entry_seq`

## Requirements
- R1: The non-maskable request is recognised only on a change of `nmi_i` from 0 to 1. If the line stays at 1, no second entry occurs at later boundaries.
- R2: A rise of `irq_i` arms a pending request. At a boundary with `mask_i`=0 the request is entered. At a boundary with `mask_i`=1 it is dropped without entry, and a later boundary with the line still high and `mask_i`=0 enters nothing.
- R3: At a boundary where `unmask_done_i`=1, a pending or asserted maskable request is not entered. The pending flag is re-armed if `irq_i` is 1, and the entry happens at the next boundary.
- R4: The entry pushes three bytes in this order: return address bits 15:8, then bits 7:0, then the status byte with bit 4 forced to 0. Each byte goes to address 0x0100 plus the stack pointer, and the pointer decrements once per byte. `set_mask_o` pulses in the same cycle as the status push.
- R5: After the pushes come two vector reads, first the low byte and then the high byte. The vector pair starts at 0xFFFA for the non-maskable request and at 0xFFFE for the maskable one. After reset the pair at 0xFFFC is read.
- R6: An entry keeps `busy_o` high for exactly 7 cycles. The first cycle comes one clock after the boundary and carries a one-cycle `take_o` pulse. Boundaries that arrive while `busy_o` is high are ignored.
- R7: A change of `so_i` from 1 to 0 gives a one-cycle `set_ovf_o` pulse one clock later. A change from 0 to 1 gives none.
- R8: During reset `sp_o` reads 0xFF and `busy_o` reads 1. After reset release only the reset vector pair is read, with no pushes, and then `busy_o` falls.
- R9: A maskable request is cleared when it is entered. With `irq_i` held at 1 and no new rise, a later boundary enters nothing.
- R10: If both requests are due at one boundary, the non-maskable one is entered. The maskable request stays pending and is entered at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_i | input | 1 | Non-maskable request, edge-triggered |
| irq_i | input | 1 | Maskable request, level |
| so_i | input | 1 | Set-overflow pin, acts on its falling edge |
| mask_i | input | 1 | Current interrupt-disable flag from the core |
| boundary_i | input | 1 | Strobe marking an instruction boundary |
| unmask_done_i | input | 1 | The instruction just finished cleared the disable flag |
| ret_addr_i | input | 16 | Return address to save |
| status_i | input | 8 | Status byte to save |
| take_o | output | 1 | First cycle of an interrupt entry |
| busy_o | output | 1 | Entry or reset-vector sequence in progress |
| push_valid_o | output | 1 | A stack write this cycle |
| push_addr_o | output | 16 | Stack write address |
| push_data_o | output | 8 | Stack write data |
| vec_rd_o | output | 1 | A vector byte read this cycle |
| vec_addr_o | output | 16 | Vector byte address |
| set_mask_o | output | 1 | Request to set the interrupt-disable flag |
| set_ovf_o | output | 1 | Request to set the overflow flag |
| sp_o | output | 8 | Stack pointer |

## Verification
The hardest case to reach from the ports is the one-instruction delay after interrupts are re-enabled. The maskable line must already be high while the mask is set, so that the pending flag is dropped first. Then a boundary with the re-enable flag must arrive and re-arm the flag without entering. The stimulus builds this in steps. It raises `irq_i`, offers one masked boundary, and checks that a plain unmasked boundary enters nothing. It then offers the re-enable boundary, which must also enter nothing, and finally a normal boundary, which must enter through 0xFFFE.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ENT_NONE = 2'd0,
    ENT_NMI  = 2'd1,
    ENT_IRQ  = 2'd2,
    ENT_RST  = 2'd3
  } entry_src_e;
endpackage

// File: rtl/pin_edge.sv
module pin_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic hit_o
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= pin_i;
  end

  generate
    if (RISING) begin : g_rise
      assign hit_o = pin_i & ~last_q;
    end else begin : g_fall
      assign hit_o = last_q & ~pin_i;
    end
  endgenerate
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic nmi_rise_i,
  input  logic irq_rise_i,
  input  logic irq_i,
  input  logic mask_i,
  input  logic boundary_i,
  input  logic unmask_done_i,
  input  logic idle_i,
  output logic take_nmi_o,
  output logic take_irq_o
);
  logic nmi_pend_q, irq_pend_q;
  logic nmi_due, irq_due, check, irq_slot;

  always_comb begin
    nmi_due    = nmi_pend_q | nmi_rise_i;
    irq_due    = irq_pend_q | irq_rise_i;
    check      = boundary_i & idle_i;
    irq_slot   = check & ~nmi_due;
    take_nmi_o = check & nmi_due;
    take_irq_o = irq_slot & ~unmask_done_i & irq_due & ~mask_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_pend_q <= 1'b0;
      irq_pend_q <= 1'b0;
    end else begin
      if (take_nmi_o)      nmi_pend_q <= 1'b0;
      else if (nmi_rise_i) nmi_pend_q <= 1'b1;

      if (irq_slot && unmask_done_i) irq_pend_q <= irq_due | irq_i;
      else if (irq_slot && irq_due)  irq_pend_q <= 1'b0;
      else if (irq_rise_i)           irq_pend_q <= 1'b1;
    end
  end

  // R9: an entered maskable request leaves nothing pending
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
    take_irq_o |=> !irq_pend_q);
  // R3: a re-enable boundary with the line high re-arms the request
  p_rearm_r3: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && idle_i && unmask_done_i && irq_i && !take_nmi_o) |=> irq_pend_q);
endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int DATA_W               = 8,
  parameter int SEQ_LEN              = 7,
  parameter int FLAG_BRK             = 4,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [2*DATA_W-1:0] VEC_NMI  = 16'hFFFA,
  parameter logic [2*DATA_W-1:0] VEC_RST  = 16'hFFFC,
  parameter logic [2*DATA_W-1:0] VEC_IRQ  = 16'hFFFE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take_nmi_i,
  input  logic                  take_irq_i,
  input  logic [2*DATA_W-1:0]   ret_addr_i,
  input  logic [DATA_W-1:0]     status_i,
  output logic                  idle_o,
  output logic                  take_o,
  output logic                  busy_o,
  output logic                  push_valid_o,
  output logic [2*DATA_W-1:0]   push_addr_o,
  output logic [DATA_W-1:0]     push_data_o,
  output logic                  vec_rd_o,
  output logic [2*DATA_W-1:0]   vec_addr_o,
  output logic                  set_mask_o,
  output logic [DATA_W-1:0]     sp_o
);
  localparam int ADDR_W  = 2 * DATA_W;
  localparam int STEP_W  = $clog2(SEQ_LEN + 1);
  localparam logic [STEP_W-1:0] ST_PUSH_HI = STEP_W'(SEQ_LEN - 4);
  localparam logic [STEP_W-1:0] ST_PUSH_LO = STEP_W'(SEQ_LEN - 3);
  localparam logic [STEP_W-1:0] ST_PUSH_ST = STEP_W'(SEQ_LEN - 2);
  localparam logic [STEP_W-1:0] ST_VEC_LO  = STEP_W'(SEQ_LEN - 1);
  localparam logic [STEP_W-1:0] ST_VEC_HI  = STEP_W'(SEQ_LEN);
  localparam logic [DATA_W-1:0] BRK_MASK   = ~(DATA_W'(1) << FLAG_BRK);

  entry_src_e          src_q;
  logic [STEP_W-1:0]   step_q, step_nxt;
  logic [ADDR_W-1:0]   ret_q, vbase;
  logic [DATA_W-1:0]   stat_q;

  assign idle_o = (step_q == '0);

  always_comb begin
    step_nxt = (step_q == ST_VEC_HI) ? '0 : step_q + 1'b1;
    unique case (src_q)
      ENT_NMI: vbase = VEC_NMI;
      ENT_IRQ: vbase = VEC_IRQ;
      default: vbase = VEC_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q       <= ST_PUSH_ST;
      src_q        <= ENT_RST;
      busy_o       <= 1'b1;
      take_o       <= 1'b0;
      push_valid_o <= 1'b0;
      push_addr_o  <= '0;
      push_data_o  <= '0;
      vec_rd_o     <= 1'b0;
      vec_addr_o   <= '0;
      set_mask_o   <= 1'b0;
      sp_o         <= '1;
      ret_q        <= '0;
      stat_q       <= '0;
    end else begin
      take_o       <= 1'b0;
      push_valid_o <= 1'b0;
      vec_rd_o     <= 1'b0;
      set_mask_o   <= 1'b0;
      if (idle_o) begin
        if (take_nmi_i || take_irq_i) begin
          step_q <= STEP_W'(1);
          busy_o <= 1'b1;
          take_o <= 1'b1;
          src_q  <= take_nmi_i ? ENT_NMI : ENT_IRQ;
          ret_q  <= ret_addr_i;
          stat_q <= status_i;
        end
      end else begin
        step_q <= step_nxt;
        busy_o <= (step_nxt != '0);
        if (step_nxt == ST_PUSH_HI || step_nxt == ST_PUSH_LO || step_nxt == ST_PUSH_ST) begin
          push_valid_o <= 1'b1;
          push_addr_o  <= {STACK_PAGE, sp_o};
          sp_o         <= sp_o - 1'b1;
        end
        if (step_nxt == ST_PUSH_HI) push_data_o <= ret_q[ADDR_W-1:DATA_W];
        if (step_nxt == ST_PUSH_LO) push_data_o <= ret_q[DATA_W-1:0];
        if (step_nxt == ST_PUSH_ST) begin
          push_data_o <= stat_q & BRK_MASK;
          set_mask_o  <= 1'b1;
        end
        if (step_nxt == ST_VEC_LO) begin
          vec_rd_o   <= 1'b1;
          vec_addr_o <= vbase;
        end
        if (step_nxt == ST_VEC_HI) begin
          vec_rd_o   <= 1'b1;
          vec_addr_o <= vbase | ADDR_W'(1);
        end
      end
    end
  end

  // R4: the mask request rides on the status push, whose break bit is clear
  p_mask_with_status_r4: assert property (@(posedge clk) disable iff (rst)
    set_mask_o |-> (push_valid_o && !push_data_o[FLAG_BRK]));
  // R4: each push leaves the pointer one below the slot it wrote
  p_sp_follows_push_r4: assert property (@(posedge clk) disable iff (rst)
    push_valid_o |-> (sp_o == DATA_W'(push_addr_o[DATA_W-1:0] - 1'b1)));
  // R5: the high vector byte directly follows its low byte
  p_vec_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (vec_rd_o && vec_addr_o[0]) |-> ($past(vec_rd_o) &&
      (ADDR_W'($past(vec_addr_o) + 1'b1) == vec_addr_o)));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int DATA_W   = 8,
  parameter int SEQ_LEN  = 7,
  parameter int FLAG_BRK = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                nmi_i,
  input  logic                irq_i,
  input  logic                so_i,
  input  logic                mask_i,
  input  logic                boundary_i,
  input  logic                unmask_done_i,
  input  logic [2*DATA_W-1:0] ret_addr_i,
  input  logic [DATA_W-1:0]   status_i,
  output logic                take_o,
  output logic                busy_o,
  output logic                push_valid_o,
  output logic [2*DATA_W-1:0] push_addr_o,
  output logic [DATA_W-1:0]   push_data_o,
  output logic                vec_rd_o,
  output logic [2*DATA_W-1:0] vec_addr_o,
  output logic                set_mask_o,
  output logic                set_ovf_o,
  output logic [DATA_W-1:0]   sp_o
);
  logic nmi_rise, irq_rise, so_fall;
  logic take_nmi, take_irq, idle;

  pin_edge #(.RISING(1'b1)) u_nmi_edge (.clk(clk), .rst(rst), .pin_i(nmi_i), .hit_o(nmi_rise));
  pin_edge #(.RISING(1'b1)) u_irq_edge (.clk(clk), .rst(rst), .pin_i(irq_i), .hit_o(irq_rise));
  pin_edge #(.RISING(1'b0)) u_so_edge  (.clk(clk), .rst(rst), .pin_i(so_i),  .hit_o(so_fall));

  always_ff @(posedge clk) begin
    if (rst) set_ovf_o <= 1'b0;
    else     set_ovf_o <= so_fall;
  end

  irq_arbiter u_arb (
    .clk(clk), .rst(rst),
    .nmi_rise_i(nmi_rise), .irq_rise_i(irq_rise), .irq_i(irq_i),
    .mask_i(mask_i), .boundary_i(boundary_i), .unmask_done_i(unmask_done_i),
    .idle_i(idle), .take_nmi_o(take_nmi), .take_irq_o(take_irq)
  );

  entry_fsm #(.DATA_W(DATA_W), .SEQ_LEN(SEQ_LEN), .FLAG_BRK(FLAG_BRK)) u_fsm (
    .clk(clk), .rst(rst),
    .take_nmi_i(take_nmi), .take_irq_i(take_irq),
    .ret_addr_i(ret_addr_i), .status_i(status_i),
    .idle_o(idle), .take_o(take_o), .busy_o(busy_o),
    .push_valid_o(push_valid_o), .push_addr_o(push_addr_o), .push_data_o(push_data_o),
    .vec_rd_o(vec_rd_o), .vec_addr_o(vec_addr_o),
    .set_mask_o(set_mask_o), .sp_o(sp_o)
  );

  // R7: an overflow request follows a 1-to-0 change of the pin
  p_ovf_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    set_ovf_o |-> (!$past(so_i) && $past(so_i, 2)));
  // R6: an entry starts only one clock after a boundary strobe
  p_take_after_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(boundary_i));
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  typedef struct packed {
    logic        is_push;
    logic [15:0] addr;
    logic [7:0]  data;
  } bus_item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic nmi_i = 0, irq_i = 0, so_i = 0, mask_i = 0, boundary_i = 0, unmask_done_i = 0;
  logic [15:0] ret_addr_i = '0;
  logic [7:0]  status_i = '0;
  logic take_o, busy_o, push_valid_o, vec_rd_o, set_mask_o, set_ovf_o;
  logic [15:0] push_addr_o, vec_addr_o;
  logic [7:0]  push_data_o, sp_o;

  int total = 0, bad = 0;
  bit done = 0;
  bus_item_t exp_q[$];
  logic [7:0] sp_m = 8'hFF;

  always #5 clk = ~clk;

  irq_entry_seq u_dut (.*);

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // monitor: compare each bus event against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && (push_valid_o || vec_rd_o)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R5 unexpected bus event", {15'd0, push_valid_o, push_addr_o}, 32'd0);
      end else begin
        bus_item_t e;
        e = exp_q.pop_front();
        check(push_valid_o == e.is_push && !(push_valid_o && vec_rd_o),
              "R4/R5 event kind", {31'd0, push_valid_o}, {31'd0, e.is_push});
        if (e.is_push) begin
          check(push_addr_o == e.addr, "R4 push address", {16'd0, push_addr_o}, {16'd0, e.addr});
          check(push_data_o == e.data, "R4 push data", {24'd0, push_data_o}, {24'd0, e.data});
        end else begin
          check(vec_addr_o == e.addr, "R5 vector address", {16'd0, vec_addr_o}, {16'd0, e.addr});
        end
      end
    end
  end

  task automatic expect_entry(input logic [15:0] vec, input logic [15:0] ra, input logic [7:0] st);
    exp_q.push_back('{1'b1, {8'h01, sp_m}, ra[15:8]});
    exp_q.push_back('{1'b1, {8'h01, 8'(sp_m - 1)}, ra[7:0]});
    exp_q.push_back('{1'b1, {8'h01, 8'(sp_m - 2)}, st & 8'hEF});
    exp_q.push_back('{1'b0, vec, 8'h00});
    exp_q.push_back('{1'b0, vec | 16'h1, 8'h00});
    sp_m = sp_m - 8'd3;
  endtask

  // drive one boundary and follow the resulting cycles
  task automatic entry(input bit want, input logic [15:0] vec, input logic [15:0] ra,
                       input logic [7:0] st, input string tag);
    ret_addr_i = ra;
    status_i   = st;
    if (want) expect_entry(vec, ra, st);
    boundary_i = 1'b1;
    tick();
    boundary_i = 1'b0;
    if (want) begin
      check(take_o && busy_o, {tag, " R6 take pulse on first cycle"}, {30'd0, take_o, busy_o}, 32'd3);
      for (int i = 2; i <= 7; i++) begin
        if (i == 3) begin
          boundary_i = 1'b1;  // R6: ignored while busy
        end
        tick();
        boundary_i = 1'b0;
        check(busy_o && !take_o, {tag, " R6 busy through entry"}, {30'd0, busy_o, take_o}, 32'd2);
        if (i == 5) check(set_mask_o, {tag, " R4 mask request with status push"}, {31'd0, set_mask_o}, 32'd1);
      end
      tick();
      check(!busy_o, {tag, " R6 busy falls after 7 cycles"}, {31'd0, busy_o}, 32'd0);
      check(sp_o == sp_m, {tag, " R4 stack pointer after entry"}, {24'd0, sp_o}, {24'd0, sp_m});
    end else begin
      check(!take_o && !busy_o, {tag, " no entry"}, {30'd0, take_o, busy_o}, 32'd0);
      tick();
    end
  endtask

  initial begin
    repeat (3) tick();
    check(busy_o && sp_o == 8'hFF && !push_valid_o, "R8 reset state", {23'd0, busy_o, sp_o}, 32'h1FF);
    exp_q.push_back('{1'b0, 16'hFFFC, 8'h00});
    exp_q.push_back('{1'b0, 16'hFFFD, 8'h00});
    rst = 1'b0;
    repeat (3) tick();
    check(!busy_o && exp_q.size() == 0, "R8 reset vector fetched", {31'd0, busy_o}, 32'd0);

    // R1: rising edge enters, held level does not
    nmi_i = 1'b1;
    tick();
    entry(1'b1, 16'hFFFA, 16'h1234, 8'hB5, "R1");
    entry(1'b0, 16'h0, 16'h2222, 8'h00, "R1 held");

    // R2: masked boundary drops the request
    irq_i = 1'b1;
    tick();
    mask_i = 1'b1;
    entry(1'b0, 16'h0, 16'h3333, 8'h04, "R2 masked");
    mask_i = 1'b0;
    entry(1'b0, 16'h0, 16'h3334, 8'h00, "R2 dropped");

    // R3: re-enable boundary defers, next boundary enters
    unmask_done_i = 1'b1;
    entry(1'b0, 16'h0, 16'h4444, 8'h00, "R3 deferred");
    unmask_done_i = 1'b0;
    entry(1'b1, 16'hFFFE, 16'hBEEF, 8'h10, "R3");

    // R9: nothing left pending after entry
    entry(1'b0, 16'h0, 16'h5555, 8'h00, "R9");

    // R10: both due, NMI first then IRQ
    nmi_i = 1'b0; irq_i = 1'b0;
    tick();
    nmi_i = 1'b1; irq_i = 1'b1;
    tick();
    entry(1'b1, 16'hFFFA, 16'hA0C3, 8'hFF, "R10");
    entry(1'b1, 16'hFFFE, 16'h0102, 8'h81, "R10 then R2");

    // R7: set-overflow pin edges
    so_i = 1'b1;
    tick();
    tick();
    check(!set_ovf_o, "R7 no request on rise", {31'd0, set_ovf_o}, 32'd0);
    so_i = 1'b0;
    tick();
    check(set_ovf_o, "R7 request after fall", {31'd0, set_ovf_o}, 32'd1);
    tick();
    check(!set_ovf_o, "R7 single-cycle request", {31'd0, set_ovf_o}, 32'd0);

    repeat (3) tick();
    check(exp_q.size() == 0, "R4/R5 all expected events seen", exp_q.size(), 32'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule